// File: doc/BRIEF.md
# DMA Stream Address and Count Sequencer

This block drives one stream of a direct-memory-access engine. It keeps a working peripheral address, a working memory address and the number of items still to move. It issues one transfer at a time: a read strobe with a source address, then a write strobe with a destination address, and then it counts the item off. A single grant input completes whichever strobe is pending. The bus logic that carries out the accesses sits outside the block.

Transfers that touch a peripheral are paced by a request/acknowledge handshake. The stream can repeat its buffer without software help (circular mode). It can also alternate between two memory buffers, so software can service one buffer while the stream fills or drains the other. The peripheral may end a transfer early through an end input when it controls the flow. A one-cycle pulse marks the halfway point and another marks completion. A buffer indicator shows which memory buffer is in use.

Configuration is captured on the rising edge of the enable input. After a stream finishes, enable must be lowered and raised again to start a new one.

Top module: `dma_stream_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `rd_req`, `wr_req`, `per_ack`, `half_flag`, `done_flag` and `cur_buf` are all 0.
- R2: A rising edge of `en` with a nonzero `item_count` starts the stream. Each transfer is one read (`rd_req`) followed by one write (`wr_req`), and each strobe stays up until `xfer_gnt` is sampled high. The `dir` encodings are:
  - 00: the peripheral address is the source and the memory address is the destination.
  - 01: the memory address is the source and the peripheral address is the destination.
  - 10: the peripheral-port address is the source and the memory address is the destination, with no request needed.
  - 11: treated as 00.
- R3: Size code 00 steps an enabled address by 1, code 01 by 2, and codes 10 or 11 by 4. When the increment bit of a port is 0, that port's address stays constant.
- R4: With `pfix` set and `pinc` set, the peripheral address steps by 4 whatever `psize` is. The memory step is unchanged.
- R5: For modes 00 and 01, `per_ack` rises when the peripheral-side access is granted. It falls only after `per_req` has been seen low. A new transfer waits for `per_req` high while `per_ack` is low.
- R6: The remaining count drops by one per completed write. When it reaches zero and neither circular nor double-buffer mode is active, the stream stops and `done_flag` pulses for one cycle.
- R7: `half_flag` pulses for one cycle when the remaining count becomes floor(programmed/2), provided that value is nonzero.
- R8: In circular mode, reaching zero reloads the count and both addresses from their programmed values, pulses `done_flag`, and the stream keeps running.
- R9: In double-buffer mode, each reload switches the memory address to the base of the other buffer and toggles `cur_buf`. Buffer 0 is used first.
- R10: In mode 10, circular and double-buffer settings are ignored, so the stream stops at zero.
- R11: With `pflow` set in mode 00 or 01, `per_eot` high while the stream waits for a request stops it and pulses `done_flag`.
- R12: Lowering `en` stops the stream without a flag. No further transfer or acknowledge happens until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Stream enable; a rising edge starts the stream |
| dir | input | 2 | Transfer direction code |
| psize | input | 2 | Peripheral-side data size code |
| msize | input | 2 | Memory-side data size code |
| pinc | input | 1 | Peripheral address increment enable |
| minc | input | 1 | Memory address increment enable |
| pfix | input | 1 | Peripheral step fixed at 4 |
| circ | input | 1 | Circular mode |
| dbuf | input | 1 | Double-buffer mode |
| pflow | input | 1 | Peripheral controls the end of the transfer |
| item_count | input | CNT_W | Programmed number of items |
| per_base | input | ADDR_W | Peripheral start address |
| mem0_base | input | ADDR_W | Memory buffer 0 start address |
| mem1_base | input | ADDR_W | Memory buffer 1 start address |
| per_req | input | 1 | Peripheral request |
| per_eot | input | 1 | Peripheral end-of-transfer |
| xfer_gnt | input | 1 | Port grant that completes the pending strobe |
| rd_req | output | 1 | Read strobe |
| rd_addr | output | ADDR_W | Read (source) address |
| wr_req | output | 1 | Write strobe |
| wr_addr | output | ADDR_W | Write (destination) address |
| per_ack | output | 1 | Acknowledge to the peripheral |
| half_flag | output | 1 | Halfway pulse |
| done_flag | output | 1 | Completion pulse |
| cur_buf | output | 1 | Memory buffer in use |

## Verification
The bench checks address sequences across every step size. It includes a byte-wide peripheral with the fixed step of 4; a design that ignored the fixed step would write to consecutive bytes, and one that applied it to the memory side would skip memory addresses.

It runs circular and double-buffer laps back to back. A wrong reload would keep counting past the buffer end, and a wrong buffer switch would send the second lap to the first buffer or report the wrong `cur_buf`.

Memory-to-memory mode runs with circular and double-buffer both set, and the stream must still stop. The peripheral-driven end is tested, and so is an enable drop followed by a fresh request that must go unanswered. A design that mishandles these would loop forever, miss the completion pulse, or raise an acknowledge while stopped.

Grant stalls check that both strobes hold their addresses until they are granted.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    localparam int DSQ_ADDR_W = 32;
    localparam int DSQ_CNT_W  = 16;
    localparam int DSQ_STEP_W = 3;

    typedef enum logic [1:0] {
        DIR_P2M = 2'b00,
        DIR_M2P = 2'b01,
        DIR_M2M = 2'b10
    } dir_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RD,
        ST_WR
    } st_e;

    typedef struct packed {
        dir_e       dir;
        logic [1:0] psize;
        logic [1:0] msize;
        logic       pinc;
        logic       minc;
        logic       pfix;
        logic       cyc;
        logic       dbuf;
        logic       pflow;
    } mode_t;

    function automatic logic [DSQ_STEP_W-1:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [DSQ_STEP_W-1:0] per_step(input mode_t m);
        if (!m.pinc) return '0;
        if (m.pfix)  return 3'd4;
        return size_bytes(m.psize);
    endfunction

    function automatic logic [DSQ_STEP_W-1:0] mem_step(input mode_t m);
        return m.minc ? size_bytes(m.msize) : '0;
    endfunction

endpackage

// File: rtl/dsq_ptr.sv
module dsq_ptr #(
    parameter int ADDR_W = dsq_pkg::DSQ_ADDR_W,
    parameter int STEP_W = dsq_pkg::DSQ_STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst)       addr <= '0;
        else if (load) addr <= load_val;
        else if (adv)  addr <= addr + ADDR_W'(step);
    end

    // R3: a zero step leaves the address where it was
    a_r3_fixed_hold: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && step == '0) |=> (addr == $past(addr)));

    // R3: an advance moves the address by exactly the step
    a_r3_step_size: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (addr == $past(addr) + ADDR_W'($past(step))));
endmodule

// File: rtl/dsq_counter.sv
module dsq_counter #(
    parameter int CNT_W = dsq_pkg::DSQ_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (dec)  cnt <= cnt - 1'b1;
    end

    // R6: one item is removed per completed transfer
    a_r6_dec_by_one: assert property (@(posedge clk) disable iff (rst)
        (dec && !load) |=> (cnt == $past(cnt) - 1'b1));

    // R6: the count never wraps below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0));
endmodule

// File: rtl/dsq_handshake.sv
module dsq_handshake (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic req,
    output logic ack
);
    always_ff @(posedge clk) begin
        if (rst)             ack <= 1'b0;
        else if (set)        ack <= 1'b1;
        else if (ack && !req) ack <= 1'b0;
    end

    // R5: acknowledge is released only after the request was seen low
    a_r5_ack_release: assert property (@(posedge clk) disable iff (rst)
        $fell(ack) |-> !$past(req));

    // R5: acknowledge only answers a live request
    a_r5_ack_on_req: assert property (@(posedge clk) disable iff (rst)
        $rose(ack) |-> $past(req));
endmodule

// File: rtl/dma_stream_seq.sv
module dma_stream_seq
    import dsq_pkg::*;
#(
    parameter int ADDR_W = DSQ_ADDR_W,
    parameter int CNT_W  = DSQ_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [1:0]        dir,
    input  logic [1:0]        psize,
    input  logic [1:0]        msize,
    input  logic              pinc,
    input  logic              minc,
    input  logic              pfix,
    input  logic              circ,
    input  logic              dbuf,
    input  logic              pflow,
    input  logic [CNT_W-1:0]  item_count,
    input  logic [ADDR_W-1:0] per_base,
    input  logic [ADDR_W-1:0] mem0_base,
    input  logic [ADDR_W-1:0] mem1_base,
    input  logic              per_req,
    input  logic              per_eot,
    input  logic              xfer_gnt,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              per_ack,
    output logic              half_flag,
    output logic              done_flag,
    output logic              cur_buf
);
    localparam int NPTR = 2;  // 0: peripheral side, 1: memory side

    mode_t             mode_in, mode_q;
    st_e               st, st_nx;
    logic              en_q;
    logic [CNT_W-1:0]  count_q, cnt, half_cnt;
    logic [ADDR_W-1:0] pbase_q, m0_q, m1_q;
    logic              start, xfer_done, last, wrap, eot_stop, ack_set;
    logic              ptr_load;
    logic [ADDR_W-1:0] ptr_val  [NPTR];
    logic [DSQ_STEP_W-1:0] ptr_step [NPTR];
    logic [ADDR_W-1:0] ptr_addr [NPTR];

    always_comb begin
        mode_in.dir   = (dir == 2'b11) ? DIR_P2M : dir_e'(dir);
        mode_in.psize = psize;
        mode_in.msize = msize;
        mode_in.pinc  = pinc;
        mode_in.minc  = minc;
        mode_in.pfix  = pfix;
        mode_in.pflow = pflow;
        mode_in.cyc   = (circ || dbuf) && (mode_in.dir != DIR_M2M);
        mode_in.dbuf  = dbuf && (mode_in.dir != DIR_M2M);
    end

    assign start     = (st == ST_IDLE) && en && !en_q && (item_count != '0);
    assign xfer_done = (st == ST_WR) && xfer_gnt;
    assign last      = xfer_done && (cnt == CNT_W'(1));
    assign wrap      = last && mode_q.cyc;
    assign eot_stop  = (st == ST_WAIT) && en && mode_q.pflow &&
                       (mode_q.dir != DIR_M2M) && per_eot;
    assign half_cnt  = count_q >> 1;
    assign ptr_load  = start || wrap;

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE: if (start) st_nx = ST_WAIT;
            ST_WAIT: begin
                if (!en || eot_stop)           st_nx = ST_IDLE;
                else if (mode_q.dir == DIR_M2M) st_nx = ST_RD;
                else if (per_req && !per_ack)  st_nx = ST_RD;
            end
            ST_RD: begin
                if (!en)          st_nx = ST_IDLE;
                else if (xfer_gnt) st_nx = ST_WR;
            end
            ST_WR: if (xfer_gnt) st_nx = (last && !mode_q.cyc) ? ST_IDLE : ST_WAIT;
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            en_q      <= 1'b0;
            mode_q    <= '0;
            count_q   <= '0;
            pbase_q   <= '0;
            m0_q      <= '0;
            m1_q      <= '0;
            cur_buf   <= 1'b0;
            half_flag <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            st        <= st_nx;
            en_q      <= en;
            half_flag <= xfer_done && (half_cnt != '0) &&
                         (CNT_W'(cnt - 1'b1) == half_cnt);
            done_flag <= last || eot_stop;
            if (start) begin
                mode_q  <= mode_in;
                count_q <= item_count;
                pbase_q <= per_base;
                m0_q    <= mem0_base;
                m1_q    <= mem1_base;
                cur_buf <= 1'b0;
            end else if (wrap && mode_q.dbuf) begin
                cur_buf <= ~cur_buf;
            end
        end
    end

    always_comb begin
        ptr_val[0]  = start ? per_base : pbase_q;
        ptr_val[1]  = start ? mem0_base :
                      (mode_q.dbuf && !cur_buf) ? m1_q : m0_q;
        ptr_step[0] = per_step(mode_q);
        ptr_step[1] = mem_step(mode_q);
    end

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dsq_ptr #(.ADDR_W(ADDR_W), .STEP_W(DSQ_STEP_W)) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .load     (ptr_load),
            .load_val (ptr_val[g]),
            .adv      (xfer_done),
            .step     (ptr_step[g]),
            .addr     (ptr_addr[g])
        );
    end

    dsq_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ptr_load),
        .load_val (start ? item_count : count_q),
        .dec      (xfer_done),
        .cnt      (cnt)
    );

    assign ack_set = xfer_gnt &&
                     (((st == ST_RD) && (mode_q.dir == DIR_P2M)) ||
                      ((st == ST_WR) && (mode_q.dir == DIR_M2P)));

    dsq_handshake u_hs (
        .clk (clk),
        .rst (rst),
        .set (ack_set),
        .req (per_req),
        .ack (per_ack)
    );

    assign rd_req  = (st == ST_RD);
    assign wr_req  = (st == ST_WR);
    assign rd_addr = (mode_q.dir == DIR_M2P) ? ptr_addr[1] : ptr_addr[0];
    assign wr_addr = (mode_q.dir == DIR_M2P) ? ptr_addr[0] : ptr_addr[1];

    // R2: read and write strobes are never raised together
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(rd_req && wr_req));

    // R2: a pending strobe keeps its address until granted
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !xfer_gnt && en) |=> (rd_req && $stable(rd_addr)));

    // R9: the buffer indicator moves only at a lap end or a fresh start
    a_r9_buf_flip: assert property (@(posedge clk) disable iff (rst)
        (cur_buf != $past(cur_buf)) |-> (done_flag || !$past(en_q)));

    // R12: no strobe while enable is low outside a write in flight
    a_r12_no_read_when_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !en_q) |-> !rd_req);
endmodule

// File: tb/dma_stream_seq_tb.sv
module dma_stream_seq_tb;
    localparam int AW = 32;
    localparam int CW = 16;

    typedef struct {
        logic          is_wr;
        logic [AW-1:0] addr;
        logic          bufv;
        string         tag;
    } item_t;

    logic          clk = 0, rst = 1, en = 0;
    logic [1:0]    dir = 0, psize = 0, msize = 0;
    logic          pinc = 0, minc = 0, pfix = 0, circ = 0, dbuf = 0, pflow = 0;
    logic [CW-1:0] item_count = 0;
    logic [AW-1:0] per_base = 0, mem0_base = 0, mem1_base = 0;
    logic          per_req = 0, per_eot = 0, xfer_gnt = 1;
    logic          rd_req, wr_req, per_ack, half_flag, done_flag, cur_buf;
    logic [AW-1:0] rd_addr, wr_addr;

    int checks = 0, failures = 0;
    int supply = 0;
    int n_half = 0, n_done = 0, n_ack = 0;
    bit gnt_stall = 0;
    item_t exp_q[$];

    always #2 clk = ~clk;  // 250 MHz

    dma_stream_seq #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .en(en), .dir(dir), .psize(psize), .msize(msize),
        .pinc(pinc), .minc(minc), .pfix(pfix), .circ(circ), .dbuf(dbuf),
        .pflow(pflow), .item_count(item_count), .per_base(per_base),
        .mem0_base(mem0_base), .mem1_base(mem1_base), .per_req(per_req),
        .per_eot(per_eot), .xfer_gnt(xfer_gnt), .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_req(wr_req), .wr_addr(wr_addr), .per_ack(per_ack),
        .half_flag(half_flag), .done_flag(done_flag), .cur_buf(cur_buf)
    );

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic w, input logic [AW-1:0] a, input logic b, input string tag);
        item_t it;
        it.is_wr = w; it.addr = a; it.bufv = b; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic observe(input logic w, input logic [AW-1:0] a, input logic b);
        item_t it;
        if (exp_q.size() == 0) begin
            chk("R12 unexpected transfer", 32'(w), 32'hFFFF_FFFF);
        end else begin
            it = exp_q.pop_front();
            chk({it.tag, " kind"}, 32'(w), 32'(it.is_wr));
            chk({it.tag, " addr"}, a, it.addr);
            if (w) chk("R9 cur_buf", 32'(b), 32'(it.bufv));
        end
    endtask

    // scoreboard monitor, also owns the grant
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_req && xfer_gnt) observe(1'b0, rd_addr, 1'b0);
            if (wr_req && xfer_gnt) observe(1'b1, wr_addr, cur_buf);
            if (half_flag) n_half++;
            if (done_flag) n_done++;
            if (per_ack)   n_ack++;
        end
        xfer_gnt = gnt_stall ? ~xfer_gnt : 1'b1;
    end

    // peripheral model
    always @(negedge clk) begin
        if (rst) per_req = 1'b0;
        else if (per_req && per_ack) per_req = 1'b0;
        else if (!per_req && !per_ack && supply > 0) begin
            per_req = 1'b1;
            supply--;
        end
    end

    task automatic cfg(input logic [1:0] d, input logic [1:0] ps, input logic [1:0] ms,
                       input logic pi, input logic mi, input logic pf,
                       input logic ci, input logic db, input logic fl, input int n);
        dir = d; psize = ps; msize = ms; pinc = pi; minc = mi; pfix = pf;
        circ = ci; dbuf = db; pflow = fl; item_count = CW'(n);
        n_half = 0; n_done = 0; n_ack = 0;
    endtask

    task automatic finish_run(input int exp_half, input int exp_done, input string tag);
        while (exp_q.size() != 0) @(negedge clk);
        repeat (8) @(negedge clk);
        chk({tag, " half pulses R7"}, 32'(n_half), 32'(exp_half));
        chk({tag, " done pulses R6"}, 32'(n_done), 32'(exp_done));
        en = 0;
        gnt_stall = 0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rd_req", 32'(rd_req), 0);
        chk("R1 wr_req", 32'(wr_req), 0);
        chk("R1 per_ack", 32'(per_ack), 0);
        chk("R1 flags", 32'({half_flag, done_flag}), 0);
        chk("R1 cur_buf", 32'(cur_buf), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 idle after reset", 32'({rd_req, wr_req, per_ack}), 0);

        // T1: R2 R3 peripheral->memory, fixed word peripheral, word memory increment
        per_base = 32'h4000_0000; mem0_base = 32'h2000_0000;
        cfg(2'b00, 2'b10, 2'b10, 0, 1, 0, 0, 0, 0, 4);
        for (int i = 0; i < 4; i++) begin
            push(0, 32'h4000_0000, 0, "R3 fixed src");
            push(1, 32'h2000_0000 + 4 * i, 0, "R2 p2m dst");
        end
        supply = 4;
        en = 1;
        finish_run(1, 1, "T1");
        chk("R5 ack seen in p2m", 32'(n_ack > 0), 1);

        // T2: R4 memory->peripheral, byte peripheral with fixed step 4, half-word memory, grant stalls
        per_base = 32'h4000_1000; mem0_base = 32'h2000_0100;
        cfg(2'b01, 2'b00, 2'b01, 1, 1, 1, 0, 0, 0, 3);
        for (int i = 0; i < 3; i++) begin
            push(0, 32'h2000_0100 + 2 * i, 0, "R3 half src");
            push(1, 32'h4000_1000 + 4 * i, 0, "R4 fixed step dst");
        end
        supply = 3; gnt_stall = 1;
        en = 1;
        finish_run(1, 1, "T2");

        // T3: R10 memory->memory, byte steps, circular and double-buffer requested but ignored
        per_base = 32'h1000_0000; mem0_base = 32'h3000_0000; mem1_base = 32'h3800_0000;
        cfg(2'b10, 2'b00, 2'b00, 1, 1, 0, 1, 1, 0, 5);
        for (int i = 0; i < 5; i++) begin
            push(0, 32'h1000_0000 + i, 0, "R10 m2m src");
            push(1, 32'h3000_0000 + i, 0, "R10 m2m dst");
        end
        supply = 0;
        en = 1;
        finish_run(1, 1, "T3 R10");
        chk("R5 no ack in m2m", 32'(n_ack), 0);

        // T4: R8 circular, two laps of two items
        per_base = 32'h4000_2000; mem0_base = 32'h2000_1000;
        cfg(2'b00, 2'b10, 2'b10, 0, 1, 0, 1, 0, 0, 2);
        for (int lap = 0; lap < 2; lap++)
            for (int i = 0; i < 2; i++) begin
                push(0, 32'h4000_2000, 0, "R8 circ src");
                push(1, 32'h2000_1000 + 4 * i, 0, "R8 circ reload dst");
            end
        supply = 4;
        en = 1;
        finish_run(2, 2, "T4 R8");

        // T5: R9 double buffer, three laps
        per_base = 32'h4000_3000; mem0_base = 32'h2000_0000; mem1_base = 32'h2000_8000;
        cfg(2'b00, 2'b10, 2'b10, 0, 1, 0, 0, 1, 0, 2);
        for (int lap = 0; lap < 3; lap++)
            for (int i = 0; i < 2; i++) begin
                push(0, 32'h4000_3000, 0, "R9 dbuf src");
                push(1, ((lap % 2) ? 32'h2000_8000 : 32'h2000_0000) + 4 * i,
                     logic'(lap % 2), "R9 dbuf dst");
            end
        supply = 6;
        en = 1;
        finish_run(3, 3, "T5 R9");

        // T6: R11 peripheral ends the transfer early
        per_base = 32'h4000_4000; mem0_base = 32'h2000_2000;
        cfg(2'b00, 2'b01, 2'b10, 1, 0, 0, 0, 0, 1, 100);
        for (int i = 0; i < 3; i++) begin
            push(0, 32'h4000_4000 + 2 * i, 0, "R11 src");
            push(1, 32'h2000_2000, 0, "R11 fixed dst");
        end
        supply = 3;
        en = 1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        per_eot = 1;
        @(negedge clk);
        per_eot = 0;
        finish_run(0, 1, "T6 R11");

        // T7: R12 enable cleared mid-stream
        per_base = 32'h4000_5000; mem0_base = 32'h2000_3000;
        cfg(2'b00, 2'b10, 2'b10, 0, 1, 0, 0, 0, 0, 8);
        for (int i = 0; i < 2; i++) begin
            push(0, 32'h4000_5000, 0, "R12 src");
            push(1, 32'h2000_3000 + 4 * i, 0, "R12 dst");
        end
        supply = 2;
        en = 1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        en = 0;
        repeat (3) @(negedge clk);
        n_ack = 0;
        supply = 1;
        repeat (20) @(negedge clk);
        chk("R12 no ack after disable", 32'(n_ack), 0);
        chk("R12 no strobe after disable", 32'({rd_req, wr_req}), 0);
        chk("R12 no flags", 32'(n_done + n_half), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule